// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block lets an external I2C master read and write a bank of 8-bit control registers that sit outside the block. It oversamples the serial clock and data lines with the system clock, recognises START, repeated START and STOP, and answers to one fixed 7-bit address as well as to the general-call byte. The bank is reached through a plain register-file port: a pointer output, write data, a one-cycle write strobe, and a combinational read-data input that must return the register selected by the pointer.

A write transfer carries the register pointer in its first data byte; each further byte lands in the register under the pointer, and the pointer then steps by one. A read transfer sends the register under the current pointer, most significant bit first, and keeps going with the next register for as long as the master acknowledges. The usual access pattern is: write the pointer, issue a repeated START, then read. The serial data line is only ever pulled low, through an output enable.

Top module: `i2c_regbank_slave`

## Requirements
- R1: An address byte of 0x30 (address 0011000, direction bit 0 = write) or 0x31 (direction bit 1 = read) is acknowledged by pulling SDA low during the ninth clock.
- R2: The general-call byte 0x00 is acknowledged and the transfer then proceeds as a write; the byte 0x01 is not acknowledged.
- R3: Any other address byte gets no acknowledge, and the block neither drives SDA nor strobes a write until the next START or STOP.
- R4: The first byte after a write address is acknowledged and loads the register pointer without producing a write strobe.
- R5: Each later write byte is acknowledged and written with a single strobe to the register under the pointer, after which the pointer steps by one, wrapping from 0xFF to 0x00.
- R6: A read starts at the pointer left by the last write or read, sends bits MSB first, and steps the pointer by one per byte sent.
- R7: A master acknowledge after a read byte makes the block send the next register; a master not-acknowledge makes it release SDA for the rest of the transfer.
- R8: A START seen in any state, including while busy or ignoring the bus, restarts address reception.
- R9: A STOP returns the block to idle from any state; a byte cut short by STOP is not written.
- R10: SDA is pulled low only in an acknowledge slot or for a 0 data bit of a read, and its drive changes only after SCL falls or on START/STOP.
- R11: After reset, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | AW | Register pointer |
| reg_wdata | output | 8 | Write data for the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
Two actions share a single system-clock cycle at the end of each write byte and each read byte: the register access at the old pointer and the step of the pointer. The bench provokes this with bursts that cross the 0xFF-to-0x00 wrap and with reads straight after writes, and judges it by comparing the bench's own register bank, filled only through the write port, against a behavioural model, and by comparing the read bytes seen on the bus. A second collision, START or STOP landing in the middle of a byte or while the slave is ignoring the bus, is forced by cutting transfers short and judged by the write count and the SDA drive that follows.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } i2cs_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);
  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      if (STAGES > 1) begin : g_multi
        assign chain_d = {chain_q[STAGES-2:0], line_i[gi]};
      end else begin : g_single
        assign chain_d = line_i[gi];
      end
      // idle bus level is high, so reset to ones
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
      end
      assign line_o[gi] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    // data moving while the clock stays high marks a bus condition
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h18,
  parameter int unsigned AW         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam int unsigned CW       = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL   = CW'(BYTE_W);
  localparam logic [CW-1:0] LASTTX = CW'(BYTE_W - 1);

  i2cs_state_e       st_q, st_d;
  byte_kind_e        kind_q, kind_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              upd_en;
  logic              addr_hit;

  assign upd_en   = scl_rise | scl_fall | start_det | stop_det;
  assign addr_hit = (sh_q[7:1] == SLAVE_ADDR) || (sh_q == '0);

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    rw_d   = rw_q;
    mack_d = mack_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    if (stop_det) begin
      st_d = ST_IDLE;
    end else if (start_det) begin
      st_d   = ST_RX;
      kind_d = BK_ADDR;
      cnt_d  = '0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            unique case (kind_q)
              BK_ADDR: begin
                if (addr_hit) begin
                  st_d = ST_ACK;
                  rw_d = sh_q[0];
                end else begin
                  st_d = ST_SKIP;
                end
              end
              BK_PTR: begin
                ptr_d = sh_q[AW-1:0];
                st_d  = ST_ACK;
              end
              default: begin
                ptr_d = ptr_q + 1'b1;
                st_d  = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (kind_q == BK_ADDR && rw_q) begin
              st_d = ST_TX;
              tx_d = reg_rdata;
            end else begin
              st_d   = ST_RX;
              kind_d = (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LASTTX) begin
              st_d  = ST_MACK;
              cnt_d = '0;
              ptr_d = ptr_q + 1'b1;
            end else begin
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d = ST_TX;
              tx_d = reg_rdata;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= BK_ADDR;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      kind_q <= kind_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      ptr_q  <= ptr_d;
    end
  end

  assign sda_oe    = (st_q == ST_ACK) || (st_q == ST_TX && !tx_q[BYTE_W-1]);
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;
  assign reg_we    = (st_q == ST_RX) && (kind_q == BK_DATA) && (cnt_q == FULL) && scl_fall;

  // R3: while ignoring the bus the line stays released
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> (!sda_oe && !reg_we));
  // R4: the pointer byte never produces a strobe
  assert_ptr_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == BK_PTR) |-> !reg_we);
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h18,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic [1:0] lines_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  i2cs_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .line_i ({scl_i, sda_i}),
    .line_o (lines_s)
  );

  i2cs_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_xfer_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (lines_s[0]),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );

  assert_we_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_we |-> scl_fall);
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_we |=> (reg_addr == AW'($past(reg_addr) + 1'b1)));
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    stop_det |=> !sda_oe);
  assert_start_release_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_det |=> !sda_oe);
  assert_oe_moves_late_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det));
endmodule

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_bus;
  logic [7:0] bank [0:255];

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  int model_wr = 0;
  int model_ptr = 0;
  logic [7:0] model_reg [0:255];
  logic chk_en = 1'b0;
  logic exp_oe = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // the external register bank, reachable only through the port
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bank[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end
  assign reg_rdata = bank[reg_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the SDA drive with the model's expectation
  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (sda_oe !== exp_oe) begin
        fails++;
        $display("FAIL R10 sda_oe actual=%0b expected=%0b", sda_oe, exp_oe);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_slot(input logic drv, input logic exp_drv, output logic seen);
    chk_en = 1'b0;
    tick(H/2);
    m_sda = drv;
    exp_oe = exp_drv;
    chk_en = 1'b1;
    tick(H/2);
    m_scl = 1'b1;
    tick(H/2);
    seen = sda_bus;
    tick(H/2);
    m_scl = 1'b0;
    chk_en = 1'b0;
  endtask

  task automatic do_start();
    chk_en = 1'b0;
    tick(H/2); m_sda = 1'b1;
    tick(H/2); m_scl = 1'b1;
    tick(H);   m_sda = 1'b0;
    tick(H);   m_scl = 1'b0;
  endtask

  task automatic do_stop();
    chk_en = 1'b0;
    tick(H/2); m_sda = 1'b0;
    tick(H/2); m_scl = 1'b1;
    tick(H);   m_sda = 1'b1;
    tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic seen;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, seen);
    bit_slot(1'b1, exp_ack, seen);
    check(!seen == exp_ack, req, int'(!seen), int'(exp_ack));
  endtask

  task automatic rd_byte(input logic mack, input string req);
    logic seen;
    logic [7:0] got;
    logic [7:0] exp;
    exp = model_reg[model_ptr];
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, !exp[i], seen);
      got[i] = seen;
    end
    bit_slot(!mack, 1'b0, seen);
    model_ptr = (model_ptr + 1) % 256;
    check(got == exp, req, got, exp);
  endtask

  task automatic wr_ptr(input logic [7:0] p);
    wr_byte(p, 1'b1, "R4 pointer byte ack");
    model_ptr = p;
  endtask

  task automatic wr_data(input logic [7:0] d);
    wr_byte(d, 1'b1, "R5 data byte ack");
    model_reg[model_ptr] = d;
    model_ptr = (model_ptr + 1) % 256;
    model_wr++;
  endtask

  task automatic check_bank(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 256; i++) begin
      if (bank[i] !== model_reg[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    check(bad == 0, req, bank[first], model_reg[first]);
    check(wr_cnt == model_wr, {req, " strobe count"}, wr_cnt, model_wr);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model_reg[i] = 8'(i) ^ 8'h5A;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    // R11 reset state
    check(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    check(reg_we == 1'b0, "R11 no strobe", reg_we, 0);

    // R1 write address, R4 pointer, R5 burst
    do_start();
    wr_byte(8'h30, 1'b1, "R1 write address ack");
    wr_ptr(8'h10);
    check(wr_cnt == model_wr, "R4 pointer byte writes nothing", wr_cnt, model_wr);
    wr_data(8'hA5); wr_data(8'h3C); wr_data(8'h7E);
    do_stop();
    check_bank("R5 burst write");

    // R6/R7/R8 combined pointer write, repeated START, read
    do_start();
    wr_byte(8'h30, 1'b1, "R1 write address ack");
    wr_ptr(8'h10);
    do_start();
    wr_byte(8'h31, 1'b1, "R8 read address after repeated start");
    rd_byte(1'b1, "R6 read byte 0");
    rd_byte(1'b1, "R7 read after master ack");
    rd_byte(1'b0, "R7 read last byte");
    tick(H);
    check(sda_oe == 1'b0, "R7 released after master nack", sda_oe, 0);
    do_stop();

    // R6 read continues from pointer left by a write
    do_start();
    wr_byte(8'h30, 1'b1, "R1 write address ack");
    wr_ptr(8'h30);
    wr_data(8'h11);
    do_stop();
    do_start();
    wr_byte(8'h31, 1'b1, "R1 read address ack");
    rd_byte(1'b0, "R6 read from leftover pointer");
    do_stop();

    // R3 foreign address ignored, R8 repeated START recovers
    do_start();
    wr_byte(8'h55, 1'b0, "R3 foreign address nack");
    wr_byte(8'h10, 1'b0, "R3 ignored byte");
    wr_byte(8'h00, 1'b0, "R3 ignored byte");
    check(wr_cnt == model_wr, "R3 no strobe while ignoring", wr_cnt, model_wr);
    do_start();
    wr_byte(8'h30, 1'b1, "R8 address after restart from ignore");
    wr_ptr(8'h40);
    wr_data(8'h77);
    do_stop();
    check_bank("R3 R8 write after restart");

    // R2 general call
    do_start();
    wr_byte(8'h00, 1'b1, "R2 general call ack");
    wr_ptr(8'h20);
    wr_data(8'h99);
    do_stop();
    check_bank("R2 general call write");
    do_start();
    wr_byte(8'h01, 1'b0, "R2 byte 0x01 nack");
    do_stop();

    // R5 pointer wrap
    do_start();
    wr_byte(8'h30, 1'b1, "R1 write address ack");
    wr_ptr(8'hFF);
    wr_data(8'h12); wr_data(8'h34);
    do_stop();
    check_bank("R5 pointer wrap");

    // R9 STOP in the middle of a data byte
    do_start();
    wr_byte(8'h30, 1'b1, "R1 write address ack");
    wr_ptr(8'h50);
    begin
      logic seen;
      for (int i = 0; i < 4; i++) bit_slot(1'b0, 1'b0, seen);
    end
    do_stop();
    check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
    check_bank("R9 cut byte not written");
    do_start();
    wr_byte(8'h31, 1'b1, "R9 new transfer after stop");
    rd_byte(1'b0, "R9 read at pointer set before stop");
    do_stop();

    tick(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule